// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block is the programming front end of a frequency synthesizer. A host writes configuration over three wires: a serial clock, a serial data line and a load strobe. Each word is 21 bits long. The first 19 bits sent are the payload and the final two bits are a control code. On the rising edge of the load strobe, the payload is copied into one of three parallel configuration latches: reference, RF divider or function. The control code picks the latch.

All three serial wires are brought into a faster system clock through two-flop synchronizers. The serial clock and the load strobe are edge-detected in that domain. A chip-enable input is synchronized the same way. It is combined with a run bit in the function latch to produce the powerdown and charge-pump tri-state outputs. A fourth control code also writes the function latch and, in addition, emits a one-cycle initialization pulse.

Top module: `synth_prog_loader`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_dat` into a 21-bit register, most significant bit first, so the first bit sent of a word lands in word bit 20.
- R2: The last two bits shifted in (word bits 1:0) are the control code. 2'b00 selects the reference latch, 2'b01 the RF divider latch, and 2'b10 and 2'b11 the function latch.
- R3: A rising edge of `ser_le` copies word bits 20:2 into bits 18:0 of the selected latch.
- R4: A load leaves the two latches that were not selected unchanged.
- R5: Shifting continues while `ser_le` stays high. Latches change only on a new rising edge of `ser_le`, never on the level.
- R6: `init_pulse` is high for exactly one system cycle for each load with code 2'b11. It stays low for every other code.
- R7: After reset all three latches read zero, `init_pulse` is low, and `pwr_down` and `cp_tristate` are high.
- R8: While `chip_en` is low, `pwr_down` and `cp_tristate` are both high, whatever the latches hold.
- R9: While `chip_en` is high, `pwr_down` and `cp_tristate` equal the inverse of function-latch bit 1 (the run bit). A run bit of 1 means operating and a run bit of 0 means powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, acts on its rising edge |
| chip_en | input | 1 | Chip enable, low forces powerdown |
| ref_word | output | 19 | Reference latch contents |
| div_word | output | 19 | RF divider latch contents |
| fn_word | output | 19 | Function latch contents |
| init_pulse | output | 1 | One-cycle pulse on a load with code 2'b11 |
| pwr_down | output | 1 | High when the synthesizer is powered down |
| cp_tristate | output | 1 | High when the charge-pump output is high impedance |

## Verification
Each serial input passes two synchronizer flops and one edge-history flop. A shift therefore lands three system cycles after a `ser_clk` rise. A latch and `init_pulse` update three cycles after a `ser_le` rise. The power outputs follow `chip_en` three cycles later, and follow a function-latch change one cycle later. The driver holds every serial level for at least three system cycles. The scoreboard monitor samples each expected item at falling clock edges, four cycles after the driver has finished the strobe or chip-enable change, so every result is already due. The `init_pulse` is counted on each falling edge over the whole run, and that running count is compared with the model.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
    localparam int WORD_W  = 21;
    localparam int CODE_W  = 2;
    localparam int LOAD_W  = WORD_W - CODE_W;
    localparam int RUN_BIT = 1;

    typedef enum logic [CODE_W-1:0] {
        SEL_REF  = 2'b00,
        SEL_DIV  = 2'b01,
        SEL_FN   = 2'b10,
        SEL_INIT = 2'b11
    } sel_code_e;

    typedef logic [LOAD_W-1:0] load_t;
endpackage

// File: rtl/prog_sync.sv
module prog_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stab;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_in;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stab;
endmodule

// File: rtl/prog_shifter.sv
module prog_shifter
    import synth_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
    } shf_st_t;

    shf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) st_d.sr = {st_q.sr[WORD_W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.sr;

    // R1: a shift moves old bits up by one place and takes the new bit at the bottom
    a_r1_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word[0] == $past(bit_in)) && (word[WORD_W-1:1] == $past(word[WORD_W-2:0])));
    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word));
endmodule

// File: rtl/prog_latch_bank.sv
module prog_latch_bank
    import synth_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_go,
    input  logic [WORD_W-1:0] word,
    output load_t             ref_q,
    output load_t             div_q,
    output load_t             fn_q,
    output logic              init_q
);
    typedef struct packed {
        load_t ref_l;
        load_t div_l;
        load_t fn_l;
        logic  init;
    } bank_st_t;

    bank_st_t  st_d, st_q;
    sel_code_e code;
    load_t     body;

    assign code = sel_code_e'(word[CODE_W-1:0]);
    assign body = word[WORD_W-1:CODE_W];

    always_comb begin
        st_d      = st_q;
        st_d.init = 1'b0;
        if (load_go) begin
            unique case (code)
                SEL_REF:  st_d.ref_l = body;
                SEL_DIV:  st_d.div_l = body;
                SEL_FN:   st_d.fn_l  = body;
                SEL_INIT: begin
                    st_d.fn_l = body;
                    st_d.init = 1'b1;
                end
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ref_q  = st_q.ref_l;
    assign div_q  = st_q.div_l;
    assign fn_q   = st_q.fn_l;
    assign init_q = st_q.init;

    // R4: one load reaches at most one latch
    a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({st_d.ref_l != st_q.ref_l, st_d.div_l != st_q.div_l,
                    st_d.fn_l != st_q.fn_l}) <= 1);
    // R5: no strobe edge, no latch change
    a_r5_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_go |=> ($stable(ref_q) && $stable(div_q) && $stable(fn_q)));
    // R6: the pulse lasts one cycle and follows a strobe
    a_r6_init_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        init_q |=> !init_q);
    a_r6_init_cause: assert property (@(posedge clk) disable iff (!rst_n)
        init_q |-> $past(load_go));
endmodule

// File: rtl/synth_prog_loader.sv
module synth_prog_loader
    import synth_prog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk,
    input  logic        ser_dat,
    input  logic        ser_le,
    input  logic        chip_en,
    output logic [18:0] ref_word,
    output logic [18:0] div_word,
    output logic [18:0] fn_word,
    output logic        init_pulse,
    output logic        pwr_down,
    output logic        cp_tristate
);
    localparam int N_SYNC = 4;
    localparam int I_CLK  = 0;
    localparam int I_DAT  = 1;
    localparam int I_LE   = 2;
    localparam int I_CE   = 3;

    typedef struct packed {
        logic clk_prev;
        logic le_prev;
        logic pd;
        logic tri_st;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic [N_SYNC-1:0] s_in;
    logic              clk_rise;
    logic              le_rise;
    logic [WORD_W-1:0] word;
    load_t             ref_l, div_l, fn_l;
    logic              init_l;

    prog_sync #(.WIDTH(N_SYNC)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({chip_en, ser_le, ser_dat, ser_clk}),
        .sync_out (s_in)
    );

    assign clk_rise = s_in[I_CLK] & ~st_q.clk_prev;
    assign le_rise  = s_in[I_LE]  & ~st_q.le_prev;

    prog_shifter i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (clk_rise),
        .bit_in   (s_in[I_DAT]),
        .word     (word)
    );

    prog_latch_bank i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_go (le_rise),
        .word    (word),
        .ref_q   (ref_l),
        .div_q   (div_l),
        .fn_q    (fn_l),
        .init_q  (init_l)
    );

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = s_in[I_CLK];
        st_d.le_prev  = s_in[I_LE];
        st_d.pd       = ~s_in[I_CE] | ~fn_l[RUN_BIT];
        st_d.tri_st   = ~s_in[I_CE] | ~fn_l[RUN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{clk_prev: 1'b0, le_prev: 1'b0, pd: 1'b1, tri_st: 1'b1};
        else        st_q <= st_d;
    end

    assign ref_word    = ref_l;
    assign div_word    = div_l;
    assign fn_word     = fn_l;
    assign init_pulse  = init_l;
    assign pwr_down    = st_q.pd;
    assign cp_tristate = st_q.tri_st;

    // R8: chip enable low forces powerdown and tri-state
    a_r8_ce_low_forces: assert property (@(posedge clk) disable iff (!rst_n)
        !s_in[I_CE] |=> (pwr_down && cp_tristate));
    // R9: chip enable high lets the run bit decide
    a_r9_run_bit_follow: assert property (@(posedge clk) disable iff (!rst_n)
        s_in[I_CE] |=> (pwr_down == ~$past(fn_l[RUN_BIT])) && (cp_tristate == pwr_down));
endmodule

// File: tb/test_synth_prog_loader.sv
module test_synth_prog_loader;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;
    localparam int SETTLE     = 4;

    typedef struct {
        logic [18:0] r, d, f;
        int          inits;
        logic        pd;
        string       tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0, chip_en = 1'b0;
    logic [18:0] ref_word, div_word, fn_word;
    logic init_pulse, pwr_down, cp_tristate;

    int total = 0, bad = 0, init_seen = 0, init_model = 0;
    logic [18:0] m_ref = '0, m_div = '0, m_fn = '0;
    exp_t exp_q[$];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_prog_loader i_synth_prog_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_le(ser_le), .chip_en(chip_en), .ref_word(ref_word),
        .div_word(div_word), .fn_word(fn_word), .init_pulse(init_pulse),
        .pwr_down(pwr_down), .cp_tristate(cp_tristate)
    );

    always @(negedge clk) if (rst_n && init_pulse) init_seen++;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(string tag);
        exp_t e;
        e.r = m_ref; e.d = m_div; e.f = m_fn; e.inits = init_model;
        e.pd = !chip_en || !m_fn[1]; e.tag = tag;
        exp_q.push_back(e);
        wait_cyc(SETTLE + 3);
    endtask

    task automatic shift_word(logic [18:0] body, logic [1:0] code);
        logic [20:0] w = {body, code};
        for (int i = 20; i >= 0; i--) begin
            ser_dat = w[i];
            wait_cyc(HOLD);
            ser_clk = 1'b1;
            wait_cyc(HOLD);
            ser_clk = 1'b0;
        end
        wait_cyc(HOLD);
    endtask

    task automatic apply_model(logic [18:0] body, logic [1:0] code);
        case (code)
            2'b00: m_ref = body;
            2'b01: m_div = body;
            2'b10: m_fn  = body;
            default: begin m_fn = body; init_model++; end
        endcase
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        wait_cyc(HOLD + 2);
        ser_le = 1'b0;
        wait_cyc(HOLD);
    endtask

    task automatic send(logic [18:0] body, logic [1:0] code, string tag);
        shift_word(body, code);
        pulse_le();
        apply_model(body, code);
        push(tag);
    endtask

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            wait (exp_q.size() != 0);
            repeat (SETTLE) @(negedge clk);
            e = exp_q.pop_front();
            check({e.tag, " R3 ref"}, ref_word, e.r);
            check({e.tag, " R4 div"}, div_word, e.d);
            check({e.tag, " R2 fn"},  fn_word,  e.f);
            check({e.tag, " R6 init count"}, init_seen, e.inits);
            check({e.tag, " R9 pwr_down"}, pwr_down, e.pd);
            check({e.tag, " R8 cp_tristate"}, cp_tristate, e.pd);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [18:0] a, b;
        wait_cyc(5);
        // R7: reset values
        check("R7 ref reset", ref_word, 0);
        check("R7 div reset", div_word, 0);
        check("R7 fn reset", fn_word, 0);
        check("R7 init reset", init_pulse, 0);
        check("R7 pwr_down reset", pwr_down, 1);
        check("R7 tristate reset", cp_tristate, 1);
        rst_n = 1'b1;
        wait_cyc(3);
        chip_en = 1'b1;
        push("R7 ce high run bit 0");

        // R1 R2 R3 R4: random payloads to every code
        for (int k = 0; k < 2; k++) begin
            send(19'($urandom), 2'b00, "R2 code00");
            send(19'($urandom), 2'b01, "R2 code01");
            send(19'($urandom) | 19'h2, 2'b10, "R2 code10");
            send(19'($urandom), 2'b11, "R6 code11");
        end
        // R1 bit order with a lone MSB and a lone LSB
        send(19'h40000, 2'b00, "R1 msb");
        send(19'h00001, 2'b01, "R1 lsb");
        // R9 run bit set then cleared via function latch
        send(19'h00002, 2'b10, "R9 run=1");
        // R8 chip enable low overrides
        chip_en = 1'b0; push("R8 ce low run=1");
        chip_en = 1'b1; push("R9 ce high run=1");
        send(19'h7fffd, 2'b10, "R9 run=0");
        chip_en = 1'b0; push("R8 ce low run=0");
        chip_en = 1'b1;

        // R5: shifting under a held strobe; no transfer until a new edge
        a = 19'($urandom); b = 19'($urandom) ^ a;
        shift_word(a, 2'b00);
        ser_le = 1'b1;
        wait_cyc(HOLD + 2);
        apply_model(a, 2'b00);
        shift_word(b, 2'b00);
        push("R5 level held");
        ser_le = 1'b0;
        wait_cyc(HOLD);
        pulse_le();
        apply_model(b, 2'b00);
        push("R5 new edge");

        wait (exp_q.size() == 0);
        wait_cyc(SETTLE + 2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule